// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes asynchronous characters off the single bidirectional data line of a contact smart card and hands them to a host through a small receive queue. A shared timing source supplies a pulse four times per elementary time unit (ETU). The receiver uses these quarter-ETU pulses to find the falling edge of a start bit and to sample each data bit in the middle of its ETU. It also checks the line level and the parity result at fixed fractional points near the end of the character.

Parity handling depends on the protocol input. In the character protocol (T=0), a character with bad parity is dropped and the receiver pulls the line low for one ETU to ask the card to send it again. Bad characters in a row are counted, and the parity flag rises only when the count reaches a host-chosen limit. In the block protocol (T=1), a character with bad parity is kept in the queue and flagged at once.

The host sets the queue depth, reads bytes through a pop strobe, and clears the sticky error flags with a status-read strobe. The interrupt line stays quiet until the queue has filled to the programmed depth or an error is latched.

Top module: `sc_char_rx`

## Requirements
- R1: A character starts when the idle line is seen low at a quarter tick, called quarter 0. If the line is high again at quarter 2, the start is a glitch and is dropped. Otherwise 8 data bits (LSB first) and a parity bit are sampled at quarters 4k+6 for k = 0..8. Parity is good when the 9 sampled bits hold an even number of ones.
- R2: The queue depth is `fifo_len`+1, so 000 gives 1 and 111 gives 8. `fifo_full` is high while the stored count equals the depth, and it drops after one byte is popped. Bytes come out in arrival order on `rd_data`, which shows the oldest stored byte.
- R3: `fifo_empty` is high while no byte is stored. It goes low as soon as a byte is stored.
- R4: `irq` equals `fifo_full` OR `overrun` OR `frame_err` OR `parity_err`. With a depth above 1, storing fewer bytes than the depth raises no interrupt.
- R5: In T=0 (`proto_t1`=0), a character with bad parity is not stored and increments an error count. `parity_err` sets when this is error number `pe_limit`+1 in a row, and the count then restarts from zero.
- R6: In T=0, a character with good parity clears the error count.
- R7: In T=1 (`proto_t1`=1), a character with bad parity is stored anyway and `parity_err` sets. No count is kept. The flag is not set before quarter 42.
- R8: The line is sampled at quarter 41 (10.25 ETU). If it is low there, `frame_err` sets and the character is not stored.
- R9: A character that would be stored while the queue is full is lost, and `overrun` sets.
- R10: In T=0 with bad parity (and a good stop level), `io_drive_low` is high for exactly 4 quarter ticks, starting at the quarter-42 tick. It is never high in T=1.
- R11: `overrun`, `frame_err` and `parity_err` stay set until a `status_rd` pulse, which clears them.
- R12: A `rd_en` pulse while the queue is empty has no effect. The queue stays empty and no byte appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| qtick | input | 1 | One-cycle pulse, four per ETU |
| io_in | input | 1 | Sampled card data line |
| io_drive_low | output | 1 | Pull the data line low (T=0 repeat request) |
| proto_t1 | input | 1 | 0 = T=0 policy, 1 = T=1 policy |
| fifo_len | input | 3 | Queue depth minus one |
| pe_limit | input | 3 | Allowed T=0 parity errors in a row, minus one |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| status_rd | input | 1 | Status read strobe; clears sticky flags |
| fifo_empty | output | 1 | No byte stored |
| fifo_full | output | 1 | Stored count equals depth |
| overrun | output | 1 | Sticky: a byte was lost on a full queue |
| frame_err | output | 1 | Sticky: stop level was low |
| parity_err | output | 1 | Sticky: parity error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every depth from 1 to 8. At each depth it checks that the full flag and the interrupt appear only on the last byte that fits, and that the next byte causes an overrun and is lost. A design that used a fixed depth, or that raised the interrupt on every byte, would fail here. The T=0 error count is tested at several limits, and a good byte is placed between bad ones to prove the count restarts. A counter that never cleared, or one off by one, would flag parity on the wrong character. The bench also times the repeat-request pulse at quarter level. It checks that parity is not flagged before 10.5 ETU. It confirms that a bad stop level discards the byte and that a low stop level is not mistaken for a new start bit.

// File: rtl/scrx_pkg.sv
package scrx_pkg;
  localparam int LEN_W      = 3;
  localparam int DEPTH_MAX  = 1 << LEN_W;
  localparam int CNT_W      = LEN_W + 1;
  localparam int DATA_W     = 8;
  localparam int QPER_ETU   = 4;
  localparam int Q_W        = 6;
  localparam int Q_GLITCH   = 2;
  localparam int Q_FIRST    = QPER_ETU + 2;
  localparam int Q_LAST     = QPER_ETU * 9 + 2;
  localparam int Q_STOPCHK  = QPER_ETU * 10 + 1;
  localparam int Q_DECIDE   = QPER_ETU * 10 + 2;
  localparam int Q_SIG_END  = Q_DECIDE + QPER_ETU;

  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic [CNT_W-1:0] depth_of(input logic [LEN_W-1:0] len);
    return {1'b0, len} + CNT_W'(1);
  endfunction

  function automatic logic is_bit_point(input logic [Q_W-1:0] q);
    return (q >= Q_W'(Q_FIRST)) && (q <= Q_W'(Q_LAST)) && (q[1:0] == 2'd2);
  endfunction
endpackage

// File: rtl/scrx_framer.sv
module scrx_framer
  import scrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qtick,
  input  logic              io_in,
  input  logic              proto_t1,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              frame_bad,
  output logic              drive_low
);
  logic           busy;
  logic [Q_W-1:0] q;
  logic [DATA_W:0] sh;
  logic           fbad;

  assign data      = sh[DATA_W-1:0];
  assign par_bad   = parity_bad(sh[DATA_W-1:0], sh[DATA_W]);
  assign frame_bad = fbad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      q         <= '0;
      sh        <= '0;
      fbad      <= 1'b0;
      done      <= 1'b0;
      drive_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (qtick) begin
        if (!busy) begin
          if (!io_in) begin
            busy <= 1'b1;
            q    <= Q_W'(1);
          end
        end else begin
          q <= q + Q_W'(1);
          if (q == Q_W'(Q_GLITCH) && io_in) busy <= 1'b0;
          if (is_bit_point(q)) sh <= {io_in, sh[DATA_W:1]};
          if (q == Q_W'(Q_STOPCHK)) fbad <= ~io_in;
          if (q == Q_W'(Q_DECIDE)) begin
            done <= 1'b1;
            if (!proto_t1 && par_bad && !fbad) drive_low <= 1'b1;
            else busy <= 1'b0;
          end
          if (q == Q_W'(Q_SIG_END)) begin
            drive_low <= 1'b0;
            busy      <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/scrx_fifo.sv
module scrx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  input  logic [$clog2(DEPTH):0]     depth,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count >= depth);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/scrx_err.sv
module scrx_err
  import scrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             par_bad,
  input  logic             frame_bad,
  input  logic             proto_t1,
  input  logic [LEN_W-1:0] pe_limit,
  input  logic             full,
  input  logic             status_rd,
  output logic             store_req,
  output logic             parity_err,
  output logic             frame_err,
  output logic             overrun
);
  logic [LEN_W-1:0] pe_cnt;
  logic set_pe, set_fe, set_ov;

  assign store_req = done && !frame_bad && (!par_bad || proto_t1);
  assign set_fe    = done && frame_bad;
  assign set_ov    = store_req && full;
  assign set_pe    = done && !frame_bad && par_bad && (proto_t1 || pe_cnt == pe_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_cnt     <= '0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (done && !frame_bad && !proto_t1) begin
        if (!par_bad || pe_cnt == pe_limit) pe_cnt <= '0;
        else pe_cnt <= pe_cnt + LEN_W'(1);
      end
      parity_err <= (parity_err && !status_rd) || set_pe;
      frame_err  <= (frame_err  && !status_rd) || set_fe;
      overrun    <= (overrun    && !status_rd) || set_ov;
    end
  end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import scrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qtick,
  input  logic             io_in,
  output logic             io_drive_low,
  input  logic             proto_t1,
  input  logic [2:0]       fifo_len,
  input  logic [2:0]       pe_limit,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             status_rd,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             overrun,
  output logic             frame_err,
  output logic             parity_err,
  output logic             irq
);
  logic              char_done, char_par_bad, char_frame_bad;
  logic [DATA_W-1:0] char_data;
  logic              store_req, store_fire;
  logic [CNT_W-1:0]  fifo_cnt;

  scrx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .io_in(io_in), .proto_t1(proto_t1),
    .done(char_done), .data(char_data), .par_bad(char_par_bad),
    .frame_bad(char_frame_bad), .drive_low(io_drive_low)
  );

  scrx_err u_err (
    .clk(clk), .rst_n(rst_n), .done(char_done), .par_bad(char_par_bad),
    .frame_bad(char_frame_bad), .proto_t1(proto_t1), .pe_limit(pe_limit),
    .full(fifo_full), .status_rd(status_rd), .store_req(store_req),
    .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun)
  );

  assign store_fire = store_req && !fifo_full;

  scrx_fifo #(.DEPTH(DEPTH_MAX), .DW(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(store_req), .wdata(char_data),
    .pop(rd_en), .depth(depth_of(fifo_len)), .rdata(rd_data),
    .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full)
  );

  assign irq = fifo_full || overrun || frame_err || parity_err;
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk
  import scrx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             proto_t1,
  input logic [2:0]       fifo_len,
  input logic             rd_en,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             overrun,
  input logic             frame_err,
  input logic             parity_err,
  input logic             irq,
  input logic             io_drive_low,
  input logic             char_done,
  input logic             char_par_bad,
  input logic             char_frame_bad,
  input logic             store_req,
  input logic             store_fire,
  input logic [CNT_W-1:0] fifo_cnt
);
  assert_empty_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_full);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= depth_of(fifo_len));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_req && fifo_full |=> overrun);

  assert_t1_keep_and_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && char_par_bad && !char_frame_bad && proto_t1 |=> parity_err && !fifo_empty);

  assert_frame_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && char_frame_bad |=> frame_err);

  assert_irq_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> irq);

  assert_no_signal_t1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_t1 |-> !io_drive_low);

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && rd_en && !store_fire |=> fifo_empty);
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .proto_t1(proto_t1), .fifo_len(fifo_len), .rd_en(rd_en),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overrun(overrun),
  .frame_err(frame_err), .parity_err(parity_err), .irq(irq),
  .io_drive_low(io_drive_low), .char_done(char_done), .char_par_bad(char_par_bad),
  .char_frame_bad(char_frame_bad), .store_req(store_req), .store_fire(store_fire),
  .fifo_cnt(fifo_cnt)
);

// File: tb/sc_char_rx_test.sv
`timescale 1ns/1ps
module sc_char_rx_test;
  logic clk = 0, rst_n = 0, qtick = 0;
  logic line = 1;
  logic io_in, io_drive_low;
  logic proto_t1 = 0, rd_en = 0, status_rd = 0;
  logic [2:0] fifo_len = 0, pe_limit = 0;
  logic [7:0] rd_data;
  logic fifo_empty, fifo_full, overrun, frame_err, parity_err, irq;
  logic [1:0] tdiv = 0;
  int tests = 0, fails = 0;
  int drv_cnt, drv_first, qi;
  logic pe_at41;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    tdiv  <= tdiv + 2'd1;
    qtick <= (tdiv == 2'd2);
  end
  assign io_in = line & ~io_drive_low;

  sc_char_rx uut (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .io_in(io_in), .io_drive_low(io_drive_low),
    .proto_t1(proto_t1), .fifo_len(fifo_len), .pe_limit(pe_limit), .rd_en(rd_en),
    .rd_data(rd_data), .status_rd(status_rd), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .overrun(overrun), .frame_err(frame_err),
    .parity_err(parity_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick;
    do @(negedge clk); while (!qtick);
    @(posedge clk); #1;
  endtask

  task automatic obs;
    wait_tick;
    if (io_drive_low) begin
      drv_cnt++;
      if (drv_first < 0) drv_first = qi;
    end
    if (qi == 41) pe_at41 = parity_err;
    qi++;
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    drv_cnt = 0; drv_first = -1; qi = 0; pe_at41 = 0;
    line = 0;
    repeat (4) obs;
    for (int b = 0; b < 9; b++) begin
      line = (b < 8) ? d[b] : ((^d) ^ bad_par);
      repeat (4) obs;
    end
    line = ~bad_stop;
    repeat (4) obs;
    line = 1;
    repeat (10) obs;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic pop;
    rd_en = 1; @(posedge clk); #1; rd_en = 0; #1;
  endtask

  task automatic clr;
    status_rd = 1; @(posedge clk); #1; status_rd = 0; #1;
  endtask

  function automatic logic [7:0] pat(input int s);
    return 8'(s * 37 + 8'h5A);
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    // reset state, R3 R11
    chk("R3 reset empty", fifo_empty, 1);
    chk("R2 reset full", fifo_full, 0);
    chk("R11 reset flags", {overrun, frame_err, parity_err}, 0);
    chk("R4 reset irq", irq, 0);
    // R12 read on empty
    pop;
    chk("R12 empty read", fifo_empty, 1);
    chk("R12 empty read no irq", irq, 0);

    // depth sweep: R1 R2 R3 R4 R9
    for (int len = 0; len < 8; len++) begin
      fifo_len = 3'(len);
      #1;
      for (int n = 1; n <= len + 1; n++) begin
        send(pat(len * 16 + n), 0, 0);
        chk("R3 not empty after store", fifo_empty, 0);
        chk("R2 full at depth", fifo_full, (n == len + 1));
        chk("R4 irq gated by depth", irq, (n == len + 1));
      end
      send(8'hC3, 0, 0);
      chk("R9 overrun on full", overrun, 1);
      for (int n = 1; n <= len + 1; n++) begin
        chk("R1 R2 data order", rd_data, pat(len * 16 + n));
        pop;
        if (n == 1) chk("R2 full clears on read", fifo_full, 0);
      end
      chk("R9 lost byte not stored", fifo_empty, 1);
      clr;
      chk("R11 overrun cleared", overrun, 0);
    end

    // T=0 parity count: R5 R10
    proto_t1 = 0;
    fifo_len = 3'd7;
    for (int lim = 0; lim < 4; lim++) begin
      pe_limit = 3'(lim);
      #1;
      for (int e = 0; e <= lim; e++) begin
        send(pat(e + 100), 1, 0);
        chk("R5 pe at threshold", parity_err, (e == lim));
        chk("R5 bad char discarded", fifo_empty, 1);
        chk("R10 repeat request width", drv_cnt, 4);
        chk("R10 repeat request start", drv_first, 42);
      end
      clr;
      chk("R11 pe cleared", parity_err, 0);
    end

    // R6 good char resets count
    pe_limit = 3'd1;
    #1;
    send(8'h11, 1, 0);
    send(8'h22, 0, 0);
    chk("R10 no request on good char", drv_cnt, 0);
    send(8'h33, 1, 0);
    chk("R6 count restarted", parity_err, 0);
    send(8'h44, 1, 0);
    chk("R6 pe after fresh errors", parity_err, 1);
    chk("R6 good char stored", rd_data, 8'h22);
    pop;
    clr;

    // T=1: R7 R10
    proto_t1 = 1;
    pe_limit = 3'd7;
    #1;
    send(8'hA5, 1, 0);
    chk("R7 pe not before 10.5 ETU", pe_at41, 0);
    chk("R7 pe set immediately", parity_err, 1);
    chk("R7 stored anyway", fifo_empty, 0);
    chk("R7 stored byte", rd_data, 8'hA5);
    chk("R10 no request in T1", drv_cnt, 0);
    pop;
    clr;

    // R8 framing
    proto_t1 = 0;
    send(8'h3C, 0, 1);
    chk("R8 frame flag", frame_err, 1);
    chk("R8 frame discard", fifo_empty, 1);
    chk("R4 irq on error", irq, 1);
    clr;
    chk("R11 frame cleared", frame_err, 0);
    send(8'h96, 0, 0);
    chk("R8 recovered after low stop", rd_data, 8'h96);
    chk("R8 no false start", frame_err, 0);
    pop;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule